// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Idle Release

This block owns the flash chip-select during continuous memory-mapped reads. The read path keeps a prefetch buffer topped up. Once that buffer is full and the bus stops asking for data, nothing useful happens on the serial link, but the flash still draws active current. An idle counter runs only while the buffer stays full with no request pending. When it reaches a programmed period, the block drops chip select and raises a sticky timeout flag.

The next read request reselects the device. It also pulses a launch strobe, which tells the serial engine to send the whole command again, with a fresh address. If the timeout is disabled, chip select stays asserted for as long as the mapped session lasts.

The serial engine and address decoding sit outside this block. They consume `cs_sel` and `cmd_launch` and provide `buf_full`.

Top module: `mmcs_cs_timeout`

## Requirements
- R1: During and right after a synchronous reset, `cs_sel`, `cmd_launch` and `tmo_flag` are all 0.
- R2: While `cs_sel` is 0, a cycle with `rd_req`=1 makes `cs_sel` 1 after the next rising edge. The same edge raises `cmd_launch` for exactly one cycle, and that pulse demands a complete command with address.
- R3: While `cs_sel` is 1 and `tmo_en` is 1, `cs_sel` falls at the rising edge that ends the (P+1)-th consecutive cycle with `buf_full`=1 and `rd_req`=0. P is `tmo_period`, a count from 0 to 65535. `tmo_flag` rises at the same edge.
- R4: A period of 0 releases chip select at the edge that ends the first full, request-free cycle.
- R5: Any cycle with `buf_full`=0 restarts the idle count from zero, so a fresh run of P+1 full cycles is needed.
- R6: A cycle with `rd_req`=1 while selected restarts the idle count and keeps `cs_sel` at 1, with no `cmd_launch` pulse.
- R7: With `tmo_en`=0, `cs_sel` stays 1 however long the buffer stays full, and `tmo_flag` is not set. Enabling the timeout later starts counting from zero.
- R8: `tmo_flag` is sticky and survives reselection. A cycle with `flag_clr`=1 clears it after the next edge. If a release happens in the same cycle as the clear, the flag ends up 1.
- R9: If `rd_req`=1 arrives in the cycle that would otherwise expire the count, the request wins: no release and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_en | input | 1 | Enables the idle release counter |
| tmo_period | input | PERIOD_W (16) | Idle period P; release follows P+1 full cycles |
| buf_full | input | 1 | Prefetch buffer is full |
| rd_req | input | 1 | A memory-mapped read request is accepted this cycle |
| flag_clr | input | 1 | Clears the timeout flag |
| cs_sel | output | 1 | Chip select asserted (1 = selected) |
| cmd_launch | output | 1 | One-cycle strobe: resend the full command with address |
| tmo_flag | output | 1 | Sticky timeout indication |

## Verification
Every output is registered, so the response to the inputs of a given cycle appears one rising edge later. For the release, that is the edge ending the (P+1)-th qualifying cycle. The bench drives inputs at the falling edge and compares all three outputs at the following falling edge, half a cycle after the edge that updates them. Directed sequences count the cycles to release for periods 0 and 3. They also cover the request-on-expiry race and the same-cycle set and clear of the flag. Random traffic with short periods is compared each cycle against a requirement-level model held in the bench.

// File: rtl/mmcs_pkg.sv
package mmcs_pkg;

    parameter int unsigned PERIOD_W_DEF = 16;

    typedef enum logic {
        LINK_OFF = 1'b0,
        LINK_ON  = 1'b1
    } link_e;

    typedef struct packed {
        logic request;
        logic expire;
    } link_ev_t;

    function automatic logic f_idle_run(input logic active, input logic enable,
                                        input logic full, input logic req);
        return active && enable && full && !req;
    endfunction

endpackage

// File: rtl/mmcs_idle_timer.sv
module mmcs_idle_timer
    import mmcs_pkg::*;
#(
    parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                enable,
    input  logic                full,
    input  logic                req,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);
    logic [PERIOD_W-1:0] count_q;
    logic                run;

    assign run    = f_idle_run(active, enable, full, req);
    assign expire = run && (count_q >= period);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (!run || expire) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // R3: a nonzero period can only expire after at least one full cycle
    a_r3_expire_after_full: assert property (@(posedge clk) disable iff (rst)
        (expire && period != '0 && $stable(period)) |-> $past(full));

    // R5: an empty buffer cycle leaves the next cycle's count at zero
    a_r5_empty_restarts: assert property (@(posedge clk) disable iff (rst)
        (!full) |=> (count_q == '0));

endmodule

// File: rtl/mmcs_link_fsm.sv
module mmcs_link_fsm
    import mmcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  link_ev_t ev,
    output logic     cs_sel,
    output logic     cmd_launch
);
    link_e state_q;
    logic  launch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LINK_OFF;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            unique case (state_q)
                LINK_OFF: if (ev.request) begin
                    state_q  <= LINK_ON;
                    launch_q <= 1'b1;
                end
                LINK_ON: if (ev.expire) begin
                    state_q <= LINK_OFF;
                end
                default: state_q <= LINK_OFF;
            endcase
        end
    end

    assign cs_sel     = (state_q == LINK_ON);
    assign cmd_launch = launch_q;

    // R2: a request while released reselects and launches a full command
    a_r2_launch_on_request: assert property (@(posedge clk) disable iff (rst)
        (!cs_sel && ev.request) |=> (cs_sel && cmd_launch));

    // R6: a request while selected never launches again
    a_r6_no_relaunch: assert property (@(posedge clk) disable iff (rst)
        (cs_sel && ev.request) |=> (cs_sel && !cmd_launch));

    // R7: without an expiry the link stays selected
    a_r7_hold_without_expire: assert property (@(posedge clk) disable iff (rst)
        (cs_sel && !ev.expire) |=> cs_sel);

endmodule

// File: rtl/mmcs_tmo_flag.sv
module mmcs_tmo_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R8: a release in the clear cycle still leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R8: a clear with no release empties the flag
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/mmcs_cs_timeout.sv
module mmcs_cs_timeout
    import mmcs_pkg::*;
#(
    parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tmo_en,
    input  logic [PERIOD_W-1:0] tmo_period,
    input  logic                buf_full,
    input  logic                rd_req,
    input  logic                flag_clr,
    output logic                cs_sel,
    output logic                cmd_launch,
    output logic                tmo_flag
);
    logic     expire;
    link_ev_t ev;

    mmcs_idle_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (cs_sel),
        .enable (tmo_en),
        .full   (buf_full),
        .req    (rd_req),
        .period (tmo_period),
        .expire (expire)
    );

    assign ev.request = rd_req;
    assign ev.expire  = expire;

    mmcs_link_fsm u_link (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .cs_sel     (cs_sel),
        .cmd_launch (cmd_launch)
    );

    mmcs_tmo_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (flag_clr),
        .flag (tmo_flag)
    );

    // R3: every release of chip select comes with the timeout flag
    a_r3_release_flags: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_sel) |-> tmo_flag);

    // R9: a request cycle never ends in a release
    a_r9_request_beats_expiry: assert property (@(posedge clk) disable iff (rst)
        (cs_sel && rd_req) |=> cs_sel);

    // R1: the launch strobe only follows a reselection
    a_r1_launch_with_select: assert property (@(posedge clk) disable iff (rst)
        cmd_launch |-> $rose(cs_sel));

endmodule

// File: tb/test_mmcs_cs_timeout.sv
`timescale 1ns/1ps
module test_mmcs_cs_timeout;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmo_en = 1'b0;
    logic [15:0] tmo_period = '0;
    logic        buf_full = 1'b0;
    logic        rd_req = 1'b0;
    logic        flag_clr = 1'b0;
    logic        cs_sel, cmd_launch, tmo_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // requirement-level reference state
    bit m_sel, m_launch, m_flag;
    int m_cnt;

    always #4 clk = ~clk;

    mmcs_cs_timeout #(.PERIOD_W(16)) i_mmcs_cs_timeout (
        .clk(clk), .rst(rst), .tmo_en(tmo_en), .tmo_period(tmo_period),
        .buf_full(buf_full), .rd_req(rd_req), .flag_clr(flag_clr),
        .cs_sel(cs_sel), .cmd_launch(cmd_launch), .tmo_flag(tmo_flag)
    );

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_edge(input bit en, input int per, input bit full,
                                       input bit req, input bit clr);
        bit setf = 0;
        m_launch = 0;
        if (!m_sel) begin
            m_cnt = 0;
            if (req) begin m_sel = 1; m_launch = 1; end
        end else if (en && full && !req) begin
            if (m_cnt >= per) begin m_sel = 0; setf = 1; m_cnt = 0; end
            else m_cnt++;
        end else begin
            m_cnt = 0;
        end
        if (setf) m_flag = 1;
        else if (clr) m_flag = 0;
    endfunction

    // drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(input bit en, input int per, input bit full,
                        input bit req, input bit clr);
        tmo_en = en; tmo_period = per[15:0]; buf_full = full;
        rd_req = req; flag_clr = clr;
        @(posedge clk);
        model_edge(en, per, full, req, clr);
        @(negedge clk);
        expect_bit("R3 cs_sel", cs_sel, m_sel);
        expect_bit("R2 cmd_launch", cmd_launch, m_launch);
        expect_bit("R8 tmo_flag", tmo_flag, m_flag);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        expect_bit("R1 cs_sel", cs_sel, 1'b0);
        expect_bit("R1 cmd_launch", cmd_launch, 1'b0);
        expect_bit("R1 tmo_flag", tmo_flag, 1'b0);
        rst = 1'b0;
        m_sel = 0; m_launch = 0; m_flag = 0; m_cnt = 0;

        // R2: request while released
        step(1, 3, 0, 1, 0);
        expect_bit("R2 select", cs_sel, 1'b1);
        expect_bit("R2 launch", cmd_launch, 1'b1);
        step(1, 3, 0, 0, 0);
        expect_bit("R2 launch one cycle", cmd_launch, 1'b0);

        // R3: period 3 releases after exactly four full cycles
        for (int k = 1; k <= 4; k++) begin
            step(1, 3, 1, 0, 0);
            expect_bit("R3 release timing", cs_sel, (k < 4));
        end
        expect_bit("R3 flag raised", tmo_flag, 1'b1);

        // R8: clear, then set and clear in the same cycle
        step(1, 0, 0, 0, 1);
        expect_bit("R8 clear", tmo_flag, 1'b0);
        step(1, 0, 0, 1, 0);
        step(1, 0, 1, 0, 1);
        expect_bit("R4 period zero release", cs_sel, 1'b0);
        expect_bit("R8 set wins over clear", tmo_flag, 1'b1);
        step(1, 0, 0, 0, 1);

        // R5: an empty cycle restarts the count
        step(1, 3, 0, 1, 0);
        for (int k = 0; k < 3; k++) step(1, 3, 1, 0, 0);
        step(1, 3, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(1, 3, 1, 0, 0);
        expect_bit("R5 still selected", cs_sel, 1'b1);
        step(1, 3, 1, 0, 0);
        expect_bit("R5 release after fresh run", cs_sel, 1'b0);

        // R6: a request while selected restarts the count, no launch
        step(1, 2, 0, 1, 1);
        step(1, 2, 1, 0, 0);
        step(1, 2, 1, 0, 0);
        step(1, 2, 1, 1, 0);
        expect_bit("R6 no relaunch", cmd_launch, 1'b0);
        step(1, 2, 1, 0, 0);
        step(1, 2, 1, 0, 0);
        expect_bit("R6 count restarted", cs_sel, 1'b1);
        step(1, 2, 1, 0, 0);
        expect_bit("R6 release after restart", cs_sel, 1'b0);

        // R9: request on the expiry cycle wins
        step(1, 1, 0, 1, 1);
        step(1, 1, 1, 0, 0);
        step(1, 1, 1, 1, 0);
        expect_bit("R9 request beats expiry", cs_sel, 1'b1);
        expect_bit("R9 no flag", tmo_flag, 1'b0);

        // R7: disabled timeout holds chip select
        for (int k = 0; k < 100; k++) step(0, 0, 1, 0, 0);
        expect_bit("R7 hold while disabled", cs_sel, 1'b1);
        expect_bit("R7 no flag while disabled", tmo_flag, 1'b0);
        step(1, 1, 1, 0, 0);
        expect_bit("R7 count starts from zero", cs_sel, 1'b1);
        step(1, 1, 1, 0, 0);
        expect_bit("R7 release after enable", cs_sel, 1'b0);

        // random traffic checked against the reference state
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4000; k++) begin
            bit en   = ($urandom % 8) != 0;
            int per  = (($urandom % 16) == 0) ? 65535 : int'($urandom % 7);
            bit full = ($urandom % 10) < 7;
            bit req  = ($urandom % 10) == 0;
            bit clr  = ($urandom % 10) == 0;
            step(en, per, full, req, clr);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule